// File: doc/BRIEF.md
# Pipelined Three-Tap FIR Filter

This block is a streaming finite impulse response filter with three taps. Each clock it can accept one signed sample. It forms a weighted sum of that sample and the two samples accepted before it. Each of the three positions has its own signed coefficient, supplied on a dedicated input. Results leave on an output with a valid strobe. Each accepted sample produces exactly one result, after a fixed latency.

The datapath is split by pipeline registers. The first stage forms the product for the newest sample and adds it to the product for the previous sample. In parallel, the same stage forms the product for the oldest sample. A second stage adds the two registered partial results. No combinational path therefore holds more than one multiplier and one adder. The cost is one extra cycle of latency. A parameter can select a flat single-stage variant, which keeps the multiplier-plus-two-adder path.

The two-stage variant is the default and is the one specified below.

Top module: `fir3_pipe`

## Requirements
- R1: Every result equals coef_a·x(n) + coef_b·x(n-1) + coef_c·x(n-2). Here x(n) is the sample accepted in that cycle, and x(n-1) and x(n-2) are the two samples accepted before it. All values are signed two's complement, and the result is bit-exact in SAMPLE_W+COEF_W+2 bits.
- R2: With the default two-stage pipeline, a sample accepted with in_valid high in cycle t produces its result with out_valid high in cycle t+2. The flat variant produces it in cycle t+1.
- R3: out_valid is high exactly once for each accepted sample and at no other time. Cycles with in_valid low do not advance the sample history, so the sample value presented in those cycles never enters any result.
- R4: While out_valid is low, out_data keeps the last result it presented.
- R5: A synchronous active-high reset clears the sample history and all pipeline registers. In the cycle after reset, out_valid is 0 and out_data is 0, and the first two results after reset use zero for the samples that precede them.
- R6: Full-scale operands produce exact results without wrap-around. For example, all samples and all coefficients at their most negative value give exactly three times 2^(SAMPLE_W+COEF_W-2).
- R7: The coefficients are sampled in the same cycle as the sample they weight. A coefficient changed from one accepted sample to the next affects only results formed from the later samples.
- R8: SAMPLE_W and COEF_W must each lie between 2 and 31, and any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | SAMPLE_W | Signed input sample |
| coef_a | input | COEF_W | Signed weight of the newest sample |
| coef_b | input | COEF_W | Signed weight of the previous sample |
| coef_c | input | COEF_W | Signed weight of the oldest sample |
| out_valid | output | 1 | A result is presented this cycle |
| out_data | output | SAMPLE_W+COEF_W+2 | Signed filter result |

## Verification
On every cycle, the assertions check four properties: out_valid follows in_valid by exactly the pipeline latency, out_data holds still whenever out_valid is low, reset leaves both outputs cleared, and no result exceeds the magnitude that three full-scale products can reach. Bit-exact arithmetic needs the bench scoreboard, which carries its own sample history and coefficient values and compares every result against it. Four behaviours show up only in the scenarios: idle cycles must not shift the history, coefficients that change per sample must weight the right sample, an impulse must bring out each coefficient in turn, and the history must restart from zero after a reset in mid-stream.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

   localparam int MIN_W = 2;
   localparam int MAX_W = 31;

   // Two guard bits above the full product width: three full-scale
   // products sum to at most 3 * 2^(P-2), well inside P+2 signed bits.
   function automatic int acc_width(input int sw, input int cw);
      return sw + cw + 2;
   endfunction

   function automatic bit width_ok(input int w);
      return (w >= MIN_W) && (w <= MAX_W);
   endfunction

endpackage

// File: rtl/fir3_tapline.sv
module fir3_tapline #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       shift_en,
   input  logic [W-1:0]               din,
   output logic [DEPTH-1:0][W-1:0]    taps
);

   logic [DEPTH-1:0][W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q[0] <= '0;
      end else if (shift_en) begin
         hist_q[0] <= din;
      end
   end

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            hist_q[k] <= '0;
         end else if (shift_en) begin
            hist_q[k] <= hist_q[k-1];
         end
      end
   end

   assign taps = hist_q;

endmodule

// File: rtl/fir3_mac.sv
module fir3_mac #(
   parameter int SAMPLE_W  = 16,
   parameter int COEF_W    = 16,
   parameter int ACC_W     = 34,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [SAMPLE_W-1:0]        x_new,
   input  logic [SAMPLE_W-1:0]        x_mid,
   input  logic [SAMPLE_W-1:0]        x_old,
   input  logic [COEF_W-1:0]          w_new,
   input  logic [COEF_W-1:0]          w_mid,
   input  logic [COEF_W-1:0]          w_old,
   output logic                       y_valid,
   output logic signed [ACC_W-1:0]    y
);

   localparam int PROD_W = SAMPLE_W + COEF_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   logic [PROD_W-1:0]        prod_new, prod_mid, prod_old;
   logic signed [ACC_W-1:0]  ext_new, ext_mid, ext_old;

   // Sign-extend both operands to the full product width so that the
   // low PROD_W bits of the unsigned product are the signed product.
   assign prod_new = {{COEF_W{x_new[SAMPLE_W-1]}}, x_new} *
                     {{SAMPLE_W{w_new[COEF_W-1]}}, w_new};
   assign prod_mid = {{COEF_W{x_mid[SAMPLE_W-1]}}, x_mid} *
                     {{SAMPLE_W{w_mid[COEF_W-1]}}, w_mid};
   assign prod_old = {{COEF_W{x_old[SAMPLE_W-1]}}, x_old} *
                     {{SAMPLE_W{w_old[COEF_W-1]}}, w_old};

   assign ext_new = {{EXT_W{prod_new[PROD_W-1]}}, prod_new};
   assign ext_mid = {{EXT_W{prod_mid[PROD_W-1]}}, prod_mid};
   assign ext_old = {{EXT_W{prod_old[PROD_W-1]}}, prod_old};

   if (PIPELINED) begin : g_split
      logic                     s1_valid;
      logic signed [ACC_W-1:0]  s1_pair;
      logic signed [ACC_W-1:0]  s1_single;

      // Stage 1: one multiplier plus one adder on the longest path.
      always_ff @(posedge clk) begin
         if (rst) begin
            s1_valid  <= 1'b0;
            s1_pair   <= '0;
            s1_single <= '0;
         end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
               s1_pair   <= ext_new + ext_mid;
               s1_single <= ext_old;
            end
         end
      end

      // Stage 2: a single adder.
      always_ff @(posedge clk) begin
         if (rst) begin
            y_valid <= 1'b0;
            y       <= '0;
         end else begin
            y_valid <= s1_valid;
            if (s1_valid) begin
               y <= s1_pair + s1_single;
            end
         end
      end
   end else begin : g_flat
      // One multiplier plus two adders in a single stage.
      always_ff @(posedge clk) begin
         if (rst) begin
            y_valid <= 1'b0;
            y       <= '0;
         end else begin
            y_valid <= in_valid;
            if (in_valid) begin
               y <= ext_new + ext_mid + ext_old;
            end
         end
      end
   end

endmodule

// File: rtl/fir3_pipe.sv
module fir3_pipe #(
   parameter int SAMPLE_W  = 16,
   parameter int COEF_W    = 16,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                                             clk,
   input  logic                                             rst,
   input  logic                                             in_valid,
   input  logic [SAMPLE_W-1:0]                              in_sample,
   input  logic [COEF_W-1:0]                                coef_a,
   input  logic [COEF_W-1:0]                                coef_b,
   input  logic [COEF_W-1:0]                                coef_c,
   output logic                                             out_valid,
   output logic signed [fir3_pkg::acc_width(SAMPLE_W, COEF_W)-1:0] out_data
);

   localparam int ACC_W     = fir3_pkg::acc_width(SAMPLE_W, COEF_W);
   localparam int HIST_TAPS = 2;

   // R8: reject widths outside the supported range at elaboration.
   if (!fir3_pkg::width_ok(SAMPLE_W)) begin : g_bad_sample_w
      $error("fir3_pipe: SAMPLE_W out of range");
   end
   if (!fir3_pkg::width_ok(COEF_W)) begin : g_bad_coef_w
      $error("fir3_pipe: COEF_W out of range");
   end

   logic [HIST_TAPS-1:0][SAMPLE_W-1:0] hist;

   fir3_tapline #(
      .W     (SAMPLE_W),
      .DEPTH (HIST_TAPS)
   ) tapline_i (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .din      (in_sample),
      .taps     (hist)
   );

   fir3_mac #(
      .SAMPLE_W  (SAMPLE_W),
      .COEF_W    (COEF_W),
      .ACC_W     (ACC_W),
      .PIPELINED (PIPELINED)
   ) mac_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .x_new    (in_sample),
      .x_mid    (hist[0]),
      .x_old    (hist[1]),
      .w_new    (coef_a),
      .w_mid    (coef_b),
      .w_old    (coef_c),
      .y_valid  (out_valid),
      .y        (out_data)
   );

endmodule

// File: rtl/fir3_pipe_chk.sv
module fir3_pipe_chk #(
   parameter int SAMPLE_W  = 16,
   parameter int COEF_W    = 16,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                                                    clk,
   input  logic                                                    rst,
   input  logic                                                    in_valid,
   input  logic                                                    out_valid,
   input  logic signed [fir3_pkg::acc_width(SAMPLE_W, COEF_W)-1:0] out_data
);

   localparam int ACC_W  = fir3_pkg::acc_width(SAMPLE_W, COEF_W);
   localparam int PROD_W = SAMPLE_W + COEF_W;
   localparam logic signed [ACC_W-1:0] BOUND =
      $signed(ACC_W'(3) << (PROD_W - 2));

   logic [1:0] seen_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_valid <= 2'b00;
      end else begin
         seen_valid <= {seen_valid[0], in_valid};
      end
   end

   // R2 / R3: out_valid mirrors in_valid after the pipeline latency.
   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid == (PIPELINED ? seen_valid[1] : seen_valid[0]));

   // R4: no change of the result while nothing is presented.
   assert_hold_data_R4: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));

   // R5: outputs are cleared one cycle after reset is seen.
   assert_reset_clear_R5: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_data == '0));

   // R6: magnitude never beyond three full-scale products.
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
      (out_data <= BOUND) && (out_data >= -BOUND));

endmodule

bind fir3_pipe fir3_pipe_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .COEF_W    (COEF_W),
   .PIPELINED (PIPELINED)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/fir3_pipe_tb_top.sv
`timescale 1ns/1ps
module fir3_pipe_tb_top;

   localparam int SW  = 16;
   localparam int CW  = 16;
   localparam int AW  = SW + CW + 2;
   localparam int LAT = 2;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic [SW-1:0]        in_sample = '0;
   logic [CW-1:0]        coef_a = '0;
   logic [CW-1:0]        coef_b = '0;
   logic [CW-1:0]        coef_c = '0;
   logic                 out_valid;
   logic signed [AW-1:0] out_data;

   fir3_pipe #(.SAMPLE_W(SW), .COEF_W(CW), .PIPELINED(1'b1)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .coef_a    (coef_a),
      .coef_b    (coef_b),
      .coef_c    (coef_c),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      longint val;
      int     due;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   int     checks = 0;
   int     fails  = 0;
   int     cyc    = 0;
   longint h1 = 0, h2 = 0;
   longint last_out = 0;
   bit     done = 1'b0;

   always @(posedge clk) cyc++;

   function automatic longint rnd_s(input int w);
      longint v;
      v = longint'($urandom) & ((64'd1 << w) - 1);
      if (v[w-1]) v = v - (64'sd1 <<< w);
      return v;
   endfunction

   // Driver: present one sample with its coefficients, push expectation.
   task automatic send(input longint x, input longint a, input longint b,
                       input longint c, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = x[SW-1:0];
      coef_a    = a[CW-1:0];
      coef_b    = b[CW-1:0];
      coef_c    = c[CW-1:0];
      e.val = a * x + b * h1 + c * h2;
      e.due = cyc + LAT;
      e.tag = tag;
      sb.push_back(e);
      h2 = h1;
      h1 = x;
   endtask

   // Idle cycles carry random junk on the data and coefficient pins (R3).
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_sample = SW'($urandom);
         coef_a    = CW'($urandom);
         coef_b    = CW'($urandom);
         coef_c    = CW'($urandom);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      h1  = 0;
      h2  = 0;
      sb.delete();
      checks++;
      if (out_valid !== 1'b0 || out_data !== '0) begin
         fails++;
         $display("FAIL R5 reset state: valid=%0b data=%0d expected valid=0 data=0",
                  out_valid, out_data);
      end
   endtask

   // Monitor: compare every result against the scoreboard head.
   always @(posedge clk) begin
      #1;
      if (!rst && !done) begin
         if (out_valid) begin
            checks++;
            if (sb.size() == 0) begin
               fails++;
               $display("FAIL R3 unexpected result: got %0d expected none", out_data);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (cyc != e.due) begin
                  fails++;
                  $display("FAIL R2 latency (%s): got cycle %0d expected %0d",
                           e.tag, cyc, e.due);
               end
               if (longint'(out_data) != e.val) begin
                  fails++;
                  $display("FAIL %s value: got %0d expected %0d",
                           e.tag, out_data, e.val);
               end
            end
         end else begin
            checks++;
            if (longint'(out_data) != last_out) begin
               fails++;
               $display("FAIL R4 hold: got %0d expected %0d", out_data, last_out);
            end
         end
      end
      last_out = longint'(out_data);
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      longint mn_s, mn_c, mx_s, mx_c;
      mn_s = -(64'sd1 <<< (SW - 1));
      mn_c = -(64'sd1 <<< (CW - 1));
      mx_s = (64'sd1 <<< (SW - 1)) - 1;
      mx_c = (64'sd1 <<< (CW - 1)) - 1;

      // R5: reset state, and the first results see zero history.
      do_reset();

      // R1: an impulse reveals each coefficient in turn.
      send(1, 3, -5, 7, "R1 impulse");
      send(0, 3, -5, 7, "R1 impulse");
      send(0, 3, -5, 7, "R1 impulse");
      send(0, 3, -5, 7, "R1 impulse");
      idle(4);

      // R1: continuous random stream with fixed random coefficients.
      begin
         longint a, b, c;
         a = rnd_s(CW); b = rnd_s(CW); c = rnd_s(CW);
         for (int i = 0; i < 300; i++) send(rnd_s(SW), a, b, c, "R1 stream");
      end
      idle(4);

      // R3: random gaps must not shift the history.
      begin
         longint a, b, c;
         a = rnd_s(CW); b = rnd_s(CW); c = rnd_s(CW);
         for (int i = 0; i < 200; i++) begin
            send(rnd_s(SW), a, b, c, "R3 gaps");
            idle(int'($urandom_range(0, 3)));
         end
      end
      idle(4);

      // R6: full-scale extremes.
      for (int i = 0; i < 4; i++) send(mn_s, mn_c, mn_c, mn_c, "R6 min");
      for (int i = 0; i < 4; i++) send(mx_s, mx_c, mx_c, mx_c, "R6 max");
      for (int i = 0; i < 4; i++) send(mn_s, mx_c, mx_c, mx_c, "R6 mixed");
      idle(4);

      // R7: coefficients change with every sample.
      for (int i = 0; i < 200; i++)
         send(rnd_s(SW), rnd_s(CW), rnd_s(CW), rnd_s(CW), "R7 coef change");

      // R5: reset in mid-stream, then the history restarts from zero.
      for (int i = 0; i < 5; i++) send(rnd_s(SW), 11, 13, 17, "R5 pre");
      do_reset();
      send(1000, 2, 4, 8, "R5 restart");
      send(2000, 2, 4, 8, "R5 restart");
      send(-300, 2, 4, 8, "R5 restart");
      idle(8);

      // R3: every accepted sample produced a result.
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R3 missing results: got %0d pending expected 0", sb.size());
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule